// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block controls how a small microcontroller enters and leaves two low-power states. In the light state ("wait") the CPU clock is turned off and the peripheral and system clocks keep running. In the deep state ("stop") every system clock is turned off. After a stop is ended by an interrupt or a break, the block counts a recovery delay that software selects before it turns the clocks back on. The block runs from a free-running reference clock that keeps running during stop. Its outputs are clock-enable signals, not gated clocks.

Three events end either low-power state: the external reset pin, an interrupt request and a break request. Reset has the highest priority. It returns the controller to the running state at once and does not request stacking. It then starts a fixed 32-cycle sequence that ends in a one-cycle vector-fetch strobe. An interrupt or a break produces a one-cycle stacking-start strobe. After a wait this strobe comes one cycle after the wake event. After a stop it comes once the recovery delay is over. A break seen while the part is in low power sets a sticky status flag. The block also drives a watchdog-active signal from a configuration bit.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset (`rst_n` low, then released and synchronised over two cycles) the controller is running. `cpu_clk_en`=1, `sys_clk_en`=1, `stack_start`=0, `brk_flag`=0 and `vec_fetch`=0.
- R2: In the running state, `wait_req` sampled high enters wait on that edge, with `cpu_clk_en`=0 and `sys_clk_en`=1. `stop_req` sampled high enters stop, with both enables 0. If both requests are high, stop wins.
- R3: The wake condition is `rst_pin` OR `irq` OR `brk`. Any of the three, sampled in wait, returns the controller to running on that edge (`cpu_clk_en`=1 in the next cycle). Requests and wake inputs have no effect while the controller is in stop with no wake event.
- R4: If a wait is ended by `irq` or `brk` without `rst_pin`, `stack_start` is high for exactly the one cycle that follows the wake edge.
- R5: A stop ended by `irq` or `brk` starts a recovery count from zero, because the counter is cleared on entry to stop. The delay D is 4096 cycles when `rec_short` was 0 at stop entry and 32 cycles when it was 1. Later changes to `rec_short` do not alter a stop already entered. If the wake is sampled on edge k, both enables go high after edge k+D-1, and `stack_start` is high for one cycle after edge k+D.
- R6: `rst_pin` sampled during wait, stop or recovery returns the controller to running on that edge, with both enables high and no `stack_start`. `vec_fetch` then pulses for one cycle after the 32nd edge that follows.
- R7: `brk` sampled during wait, stop or recovery sets `brk_flag`, and the flag stays set. `brk` in the running state leaves `brk_flag` unchanged.
- R8: A one-cycle `brk_clr` clears `brk_flag`. If a set and a clear happen in the same cycle, the set wins. `rst_pin` clears `brk_flag` and has priority over a set.
- R9: `wdog_active` equals NOT `wdog_dis` while the controller is running or in wait. It is 0 during stop and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | CPU request to enter wait |
| stop_req | input | 1 | CPU request to enter stop |
| rst_pin | input | 1 | External reset pin, active high |
| irq | input | 1 | Interrupt request |
| brk | input | 1 | Break request |
| rec_short | input | 1 | Recovery select: 1 = short delay, 0 = long delay |
| wdog_dis | input | 1 | Watchdog disable configuration bit |
| brk_clr | input | 1 | One-cycle clear strobe for the break flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System/bus clock enable |
| stack_start | output | 1 | One-cycle strobe that starts interrupt stacking |
| brk_flag | output | 1 | Sticky break-during-low-power status |
| wdog_active | output | 1 | Watchdog running indication |
| vec_fetch | output | 1 | One-cycle strobe that starts the reset vector fetch |

## Verification
Every result has a fixed latency from the edge that samples its stimulus:
- Mode changes and the wait-exit `stack_start` appear one cycle after that edge.
- The stop-exit clock enables appear D edges after the wake edge, for D = 32 and D = 4096. `stack_start` follows one edge after the enables.
- `vec_fetch` appears 32 edges after a reset exit.

The bench drives inputs on the falling edge and reads outputs at the next falling edge, so each read covers exactly one rising edge. For the recovery delay it counts edges until the enables rise and compares the count with D. It also checks the cycle just before each strobe and the cycle just after it, so a strobe that is early, late or stretched is reported.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_STOP  = 2'd2,
    ST_RECOV = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_recov_timer.sv
module lpm_recov_timer #(
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32,
  localparam int CW = $clog2(LONG_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_load_i,
  input  logic sel_i,
  input  logic run_i,
  output logic term_o
);
  logic          sel_q, sel_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dly;

  assign dly    = sel_q ? CW'(SHORT_DLY) : CW'(LONG_DLY);
  assign term_o = run_i && (cnt_q == dly - CW'(1));

  always_comb begin
    sel_d = sel_load_i ? sel_i : sel_q;
    if (!run_i)      cnt_d = '0;
    else if (term_o) cnt_d = cnt_q;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: the counter is held at zero outside recovery, so every recovery count starts from zero
  a_r5_cleared_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  // R5: the counter never goes past the selected delay
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < dly));
endmodule

// File: rtl/lpm_rst_seq.sv
module lpm_rst_seq #(
  parameter int SEQ_CYC = 32,
  localparam int SW = $clog2(SEQ_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic fetch_o
);
  logic [SW-1:0] cnt_q, cnt_d;
  logic          fetch_q, fetch_d;

  always_comb begin
    if (start_i)            cnt_d = SW'(SEQ_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - SW'(1);
    else                    cnt_d = cnt_q;
    fetch_d = (cnt_q == SW'(1)) && !start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fetch_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fetch_q <= fetch_d;
    end
  end

  assign fetch_o = fetch_q;

  // R6: the vector-fetch strobe lasts exactly one cycle
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |=> !fetch_o);
endmodule

// File: rtl/lpm_brk_status.sv
module lpm_brk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  input  logic in_lp_i,
  input  logic rst_pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    if (rst_pin_i)             flag_d = 1'b0;
    else if (brk_i && in_lp_i) flag_d = 1'b1;
    else if (clr_i)            flag_d = 1'b0;
    else                       flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R7: a break while in low power sets the flag, even if a clear arrives in the same cycle
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && in_lp_i && !rst_pin_i) |=> flag_o);
  // R7: with no clear and no reset pin, a set flag stays set
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i && !rst_pin_i) |=> flag_o);
  // R8: the reset pin clears the flag
  a_r8_pin_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_i |=> !flag_o);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req_i,
  input  logic       stop_req_i,
  input  logic       rst_pin_i,
  input  logic       irq_i,
  input  logic       brk_i,
  input  logic       term_i,
  output lpm_state_e state_o,
  output logic       stop_entry_o,
  output logic       rst_exit_o,
  output logic       stack_o
);
  lpm_state_e state_q, state_d;
  logic       stack_q, stack_d;
  logic       soft_wake;

  assign soft_wake = irq_i || brk_i;

  always_comb begin
    state_d      = state_q;
    stack_d      = 1'b0;
    stop_entry_o = 1'b0;
    rst_exit_o   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req_i) begin
          state_d      = ST_STOP;
          stop_entry_o = 1'b1;
        end else if (wait_req_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rst_pin_i) begin
          state_d    = ST_RUN;
          rst_exit_o = 1'b1;
        end else if (soft_wake) begin
          state_d = ST_RUN;
          stack_d = 1'b1;
        end
      end
      ST_STOP: begin
        if (rst_pin_i) begin
          state_d    = ST_RUN;
          rst_exit_o = 1'b1;
        end else if (soft_wake) begin
          state_d = ST_RECOV;
        end
      end
      ST_RECOV: begin
        if (rst_pin_i) begin
          state_d    = ST_RUN;
          rst_exit_o = 1'b1;
        end else if (term_i) begin
          state_d = ST_RUN;
          stack_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      stack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stack_q <= stack_d;
    end
  end

  assign state_o = state_q;
  assign stack_o = stack_q;

  // R4: a wait ended by an interrupt or a break strobes stacking in the following cycle
  a_r4_wait_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && soft_wake && !rst_pin_i) |=> stack_o);
  // R6: a reset exit never requests stacking
  a_r6_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && rst_pin_i) |=> (!stack_o && state_q == ST_RUN));
  // R4: the stacking strobe lasts exactly one cycle
  a_r4_stack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stack_o |=> !stack_o);
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32,
  parameter int SEQ_CYC   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  input  logic rst_pin,
  input  logic irq,
  input  logic brk,
  input  logic rec_short,
  input  logic wdog_dis,
  input  logic brk_clr,
  output logic cpu_clk_en,
  output logic sys_clk_en,
  output logic stack_start,
  output logic brk_flag,
  output logic wdog_active,
  output logic vec_fetch
);
  logic [1:0] rsync_q;
  logic       srst_n;
  lpm_state_e state;
  logic       stop_entry, rst_exit, term, in_lp, recov;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  lpm_fsm i_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .wait_req_i   (wait_req),
    .stop_req_i   (stop_req),
    .rst_pin_i    (rst_pin),
    .irq_i        (irq),
    .brk_i        (brk),
    .term_i       (term),
    .state_o      (state),
    .stop_entry_o (stop_entry),
    .rst_exit_o   (rst_exit),
    .stack_o      (stack_start)
  );

  assign recov = (state == ST_RECOV);
  assign in_lp = (state != ST_RUN);

  lpm_recov_timer #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) i_timer (
    .clk        (clk),
    .rst_n      (srst_n),
    .sel_load_i (stop_entry),
    .sel_i      (rec_short),
    .run_i      (recov),
    .term_o     (term)
  );

  lpm_rst_seq #(.SEQ_CYC(SEQ_CYC)) i_rseq (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (rst_exit),
    .fetch_o (vec_fetch)
  );

  lpm_brk_status i_brk (
    .clk       (clk),
    .rst_n     (srst_n),
    .brk_i     (brk),
    .in_lp_i   (in_lp),
    .rst_pin_i (rst_pin),
    .clr_i     (brk_clr),
    .flag_o    (brk_flag)
  );

  // clock enables come back in the same cycle the recovery count reaches its end
  assign cpu_clk_en  = (state == ST_RUN) || (recov && term);
  assign sys_clk_en  = (state == ST_RUN) || (state == ST_WAIT) || (recov && term);
  assign wdog_active = !wdog_dis && ((state == ST_RUN) || (state == ST_WAIT));

  // R3: the CPU clock never runs without the system clock
  a_r3_cpu_needs_sys: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_clk_en |-> sys_clk_en);
  // R2: a stop request in the running state shuts both enables on the next cycle
  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_RUN && stop_req) |=> (!sys_clk_en && !cpu_clk_en));
  // R9: the watchdog stays active throughout wait when it is not disabled
  a_r9_wdog_wait: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_WAIT && !wdog_dis) |-> wdog_active);
endmodule

// File: tb/test_lpm_seq_ctrl.sv
module test_lpm_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, rst_pin = 0, irq = 0, brk = 0;
  logic rec_short = 0, wdog_dis = 0, brk_clr = 0;
  logic cpu_clk_en, sys_clk_en, stack_start, brk_flag, wdog_active, vec_fetch;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lpm_seq_ctrl i_lpm_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .rst_pin(rst_pin), .irq(irq), .brk(brk), .rec_short(rec_short),
    .wdog_dis(wdog_dis), .brk_clr(brk_clr), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .stack_start(stack_start), .brk_flag(brk_flag),
    .wdog_active(wdog_active), .vec_fetch(vec_fetch)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_stop(input logic sel);
    rec_short = sel; stop_req = 1; tick(); stop_req = 0;
    rec_short = ~sel;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick();
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 sys_clk_en", sys_clk_en, 1);
    chk("R1 stack_start", stack_start, 0);
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 vec_fetch", vec_fetch, 0);

    // R7: a break in the running state is ignored
    brk = 1; tick(); brk = 0;
    chk("R7 brk in run ignored", brk_flag, 0);
    chk("R7 no stack in run", stack_start, 0);

    // R2: stop wins over wait
    wait_req = 1; stop_req = 1; tick(); wait_req = 0; stop_req = 0;
    chk("R2 both req cpu", cpu_clk_en, 0);
    chk("R2 both req sys", sys_clk_en, 0);
    rst_pin = 1; tick(); rst_pin = 0;
    chk("R6 reset exit stop sys", sys_clk_en, 1);
    chk("R6 reset exit no stack", stack_start, 0);
    repeat (31) tick();
    chk("R6 vec_fetch not early", vec_fetch, 0);
    tick();
    chk("R6 vec_fetch at 32", vec_fetch, 1);
    tick();
    chk("R6 vec_fetch one cycle", vec_fetch, 0);

    // wait sweep: wake source x watchdog disable
    for (int src = 0; src < 3; src++) begin
      for (int wd = 0; wd < 2; wd++) begin
        wdog_dis = wd[0];
        brk_clr = 1; tick(); brk_clr = 0;
        wait_req = 1; tick(); wait_req = 0;
        chk("R2 wait cpu off", cpu_clk_en, 0);
        chk("R2 wait sys on", sys_clk_en, 1);
        chk("R9 wdog in wait", wdog_active, 1 - wd);
        tick();
        chk("R3 wait holds", cpu_clk_en, 0);
        if (src == 0) irq = 1; else if (src == 1) brk = 1; else rst_pin = 1;
        tick(); irq = 0; brk = 0; rst_pin = 0;
        chk("R3 wake cpu on", cpu_clk_en, 1);
        chk("R4 stack after wait wake", stack_start, (src != 2) ? 1 : 0);
        chk("R7 flag after wake", brk_flag, (src == 1) ? 1 : 0);
        chk("R9 wdog in run", wdog_active, 1 - wd);
        tick();
        chk("R4 stack one cycle", stack_start, 0);
        if (src == 1) chk("R7 flag sticky", brk_flag, 1);
        repeat (35) tick();
      end
    end
    wdog_dis = 0;

    // R8: a clear and a set in the same cycle, the set wins
    brk_clr = 1; tick(); brk_clr = 0;
    chk("R8 clear", brk_flag, 0);
    wait_req = 1; tick(); wait_req = 0;
    brk = 1; brk_clr = 1; tick(); brk = 0; brk_clr = 0;
    chk("R8 set beats clear", brk_flag, 1);
    // R8: the reset pin beats a break
    wait_req = 1; tick(); wait_req = 0;
    brk = 1; rst_pin = 1; tick(); brk = 0; rst_pin = 0;
    chk("R8 pin beats set", brk_flag, 0);
    chk("R6 pin+brk no stack", stack_start, 0);
    repeat (35) tick();

    // stop recovery sweep: select x source
    for (int sel = 0; sel < 2; sel++) begin
      for (int src = 0; src < 2; src++) begin
        int d, n;
        d = (sel == 1) ? 32 : 4096;
        go_stop(sel[0]);
        chk("R2 stop sys off", sys_clk_en, 0);
        chk("R9 wdog off in stop", wdog_active, 0);
        wait_req = 1; tick(); tick(); wait_req = 0;
        chk("R3 stop holds", sys_clk_en, 0);
        if (src == 0) irq = 1; else brk = 1;
        tick(); irq = 0; brk = 0;
        n = 1;
        while (!sys_clk_en && n < 5000) begin tick(); n++; end
        chk("R5 recovery length", n, d);
        chk("R5 cpu with sys", cpu_clk_en, 1);
        chk("R5 stack not yet", stack_start, 0);
        tick();
        chk("R5 stack after recovery", stack_start, 1);
        chk("R7 flag after stop", brk_flag, src);
        tick();
        chk("R5 stack one cycle", stack_start, 0);
        brk_clr = 1; tick(); brk_clr = 0;
      end
    end

    // R6: reset pin during recovery
    go_stop(1'b1);
    irq = 1; tick(); irq = 0;
    repeat (5) tick();
    chk("R5 still recovering", sys_clk_en, 0);
    rst_pin = 1; tick(); rst_pin = 0;
    chk("R6 reset in recovery", cpu_clk_en, 1);
    chk("R6 no stack recovery", stack_start, 0);
    repeat (40) tick();
    chk("R6 stays run", cpu_clk_en, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule